// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves the source operand of one already-decoded instruction. A start strobe hands it an addressing-mode code, the instruction's value field, a register number, the program counter and a destination flag. The unit latches them and, one cycle later, reads the named register through a register-file read port. It then forms an effective address and issues exactly the number of data-memory reads that the mode calls for. When it has the operand it returns it together with the effective address and the number of data reads it made, and pulses done for one cycle.

The data-memory side is a single read port. The unit raises a request with an address and holds both until the memory answers with a one-cycle valid strobe carrying the read data. Pointer modes chain reads back to back: each returned word becomes the next address. Effective-address sums treat the register contents and the displacement as two's-complement values and wrap silently at the address width.

Top module: `amf_operand_fetch`

## Requirements
- R1: Immediate mode (code 0) returns the full value field as the operand, reports an effective address of 0 and a count of 0, and makes no data read.
- R2: Register mode (code 1) returns the contents of the register named by the register number, with effective address 0, count 0 and no data read.
- R3: Direct mode (code 2) uses the low address-width bits of the value field as the effective address and makes one read, whose data is the operand.
- R4: Indirect mode (code 3) reads at the address field to obtain a pointer, then reads at the pointer. The effective address is the pointer and the count is 2, also when the pointer points to its own cell.
- R5: Indexed mode (code 4) uses the address field plus the register contents, taken as signed and summed modulo 2^AW, as the effective address. It makes one read.
- R6: Register-indirect mode (code 5) uses the register contents as the effective address and returns the memory word there, not the register value. It makes one read.
- R7: PC-relative mode (code 6) uses PC plus the sign-extended low 8 bits of the value field, modulo 2^AW, as the effective address. It makes one read, so a zero displacement addresses the PC itself.
- R8: Double-indirect mode (code 7) follows two pointers and then reads the operand, for a count of 3. The effective address is the second pointer.
- R9: Immediate mode with the destination flag set raises error in the same cycle as done, with a count of 0 and no memory request.
- R10: The request address stays constant until valid arrives. The count rises by one for each completed read. Done is a one-cycle pulse, and the number of valid strobes the memory gives equals the reported count.
- R11: A start that arrives while an operation is in progress is ignored. The running operation finishes with its own result, and no extra operation follows.
- R12: After reset, done, error, the request and the count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving an operand (taken only when idle) |
| mode | input | 3 | Addressing-mode code |
| is_dest | input | 1 | Operand is used as a destination |
| value_field | input | DW | Instruction immediate / address / displacement field |
| reg_sel | input | RW | Register number |
| pc | input | AW | Address of the current instruction |
| rf_addr | output | RW | Register-file read address |
| rf_data | input | DW | Register-file read data (same cycle) |
| mem_req | output | 1 | Data read request |
| mem_addr | output | AW | Data read address |
| mem_rdata | input | DW | Data read result |
| mem_valid | input | 1 | Read data valid strobe |
| operand | output | DW | Resolved operand |
| eff_addr | output | AW | Effective address of the operand |
| access_cnt | output | 2 | Data reads made by the last operation |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Immediate used as destination (with done) |

## Verification
The assertions assume that the memory raises valid only while a request is pending, for one cycle per read, and that the register file answers in the cycle it is addressed. The bench memory model responds only to an open request, pulses valid for one cycle, and inserts a random wait of zero to two cycles. Its contents come from a fixed hash, with one cell made to point to itself. Random operations start only when the unit is idle, except in one directed case that injects a start on purpose while the unit is busy.

// File: rtl/amf_pkg.sv
// Package: shared addressing-mode codes and read-count table for the
// operand fetch unit. Assumes codes are fixed and decoded by neighbours.
package amf_pkg;
    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_REG  = 3'd1,
        AM_DIR  = 3'd2,
        AM_IND  = 3'd3,
        AM_IDX  = 3'd4,
        AM_RIND = 3'd5,
        AM_PCR  = 3'd6,
        AM_DIND = 3'd7
    } amode_t;

    localparam int MAX_READS = 3;
    localparam int CNT_W     = $clog2(MAX_READS + 1);

    // Number of data reads a mode needs.
    function automatic logic [CNT_W-1:0] reads_for(amode_t m);
        case (m)
            AM_IMM, AM_REG:               reads_for = CNT_W'(0);
            AM_DIR, AM_IDX, AM_RIND, AM_PCR: reads_for = CNT_W'(1);
            AM_IND:                       reads_for = CNT_W'(2);
            default:                      reads_for = CNT_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/amf_ea_calc.sv
// Module: amf_ea_calc
// Combinational address former. From the latched mode, value field,
// register value and PC it produces the first address to read, the
// operand for modes with no read, and the number of reads required.
// Assumes DISP_W <= AW. Register contents are signed; sums wrap at AW.
module amf_ea_calc
    import amf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 16,
    parameter int DISP_W = 8
) (
    input  amode_t           mode_i,
    input  logic [DW-1:0]    value_i,
    input  logic [DW-1:0]    rf_val_i,
    input  logic [AW-1:0]    pc_i,
    output logic [AW-1:0]    first_addr_o,
    output logic [DW-1:0]    direct_val_o,
    output logic [CNT_W-1:0] nreads_o
);
    logic [AW-1:0] field_a;
    logic [AW-1:0] index_a;
    logic [AW-1:0] disp_a;

    // Address field and register value resized to the address width.
    generate
        if (DW >= AW) begin : g_trunc
            assign field_a = value_i[AW-1:0];
            assign index_a = rf_val_i[AW-1:0];
        end else begin : g_ext
            assign field_a = {{(AW-DW){1'b0}}, value_i};
            assign index_a = {{(AW-DW){rf_val_i[DW-1]}}, rf_val_i};
        end
        if (DISP_W < AW) begin : g_dsx
            assign disp_a = {{(AW-DISP_W){value_i[DISP_W-1]}}, value_i[DISP_W-1:0]};
        end else begin : g_dfull
            assign disp_a = value_i[AW-1:0];
        end
    endgenerate

    // Select the first read address per mode (modular sums).
    always_comb begin
        case (mode_i)
            AM_IDX:  first_addr_o = field_a + index_a;
            AM_RIND: first_addr_o = index_a;
            AM_PCR:  first_addr_o = pc_i + disp_a;
            default: first_addr_o = field_a;
        endcase
    end

    // Operand for the modes that need no read.
    always_comb begin
        direct_val_o = (mode_i == AM_REG) ? rf_val_i : value_i;
    end

    assign nreads_o = reads_for(mode_i);
endmodule

// File: rtl/amf_seq.sv
// Module: amf_seq
// Read sequencer. Waits one cycle for the address former, then issues
// exactly nreads_i chained reads. Each returned word except the last
// becomes the next address. Assumes mem_valid pulses for one cycle per
// read and only while mem_req is high.
module amf_seq
    import amf_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  amode_t           mode_q_i,
    input  logic             dest_q_i,
    input  logic [AW-1:0]    first_addr_i,
    input  logic [DW-1:0]    direct_val_i,
    input  logic [CNT_W-1:0] nreads_i,
    input  logic             mem_valid_i,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    operand_o,
    output logic [AW-1:0]    eff_addr_o,
    output logic [CNT_W-1:0] access_cnt_o,
    output logic             done_o,
    output logic             error_o
);
    typedef enum logic [1:0] {S_IDLE, S_CALC, S_WAIT} st_t;
    st_t              state;
    logic [CNT_W-1:0] left_q;
    logic [AW-1:0]    next_addr;

    assign accept_o = start_i && (state == S_IDLE);
    assign busy_o   = (state != S_IDLE);

    // Returned word reused as the next address.
    generate
        if (DW >= AW) begin : g_ptr_trunc
            assign next_addr = mem_rdata_i[AW-1:0];
        end else begin : g_ptr_ext
            assign next_addr = {{(AW-DW){1'b0}}, mem_rdata_i};
        end
    endgenerate

    // Main sequencer: accept, compute, chained reads, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            left_q       <= '0;
            mem_req_o    <= 1'b0;
            mem_addr_o   <= '0;
            operand_o    <= '0;
            eff_addr_o   <= '0;
            access_cnt_o <= '0;
            done_o       <= 1'b0;
            error_o      <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            error_o <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_i) begin
                        access_cnt_o <= '0;
                        state        <= S_CALC;
                    end
                end
                S_CALC: begin
                    if (mode_q_i == AM_IMM && dest_q_i) begin
                        error_o    <= 1'b1;
                        done_o     <= 1'b1;
                        eff_addr_o <= '0;
                        state      <= S_IDLE;
                    end else if (nreads_i == '0) begin
                        operand_o  <= direct_val_i;
                        eff_addr_o <= '0;
                        done_o     <= 1'b1;
                        state      <= S_IDLE;
                    end else begin
                        mem_req_o  <= 1'b1;
                        mem_addr_o <= first_addr_i;
                        left_q     <= nreads_i;
                        state      <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_valid_i) begin
                        access_cnt_o <= access_cnt_o + CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            operand_o  <= mem_rdata_i;
                            eff_addr_o <= mem_addr_o;
                            mem_req_o  <= 1'b0;
                            done_o     <= 1'b1;
                            state      <= S_IDLE;
                        end else begin
                            mem_addr_o <= next_addr;
                            left_q     <= left_q - CNT_W'(1);
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10: request and address held until the read completes
    p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R10: done lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: each completed read advances the count by one
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_valid_i) |=> (access_cnt_o == $past(access_cnt_o) + CNT_W'(1)));

    // R9: error comes with done, no request and no reads
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (done_o && !mem_req_o && access_cnt_o == '0));

    // R4 / R8: a fixed number of reads, never a loop
    p_no_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> (access_cnt_o == nreads_i));
endmodule

// File: rtl/amf_operand_fetch.sv
// Module: amf_operand_fetch (top)
// Latches one decoded instruction on an accepted start, reads the named
// register, forms the effective address and runs the read sequencer.
// Assumes a register file that answers combinationally, and a data
// memory that answers a held request with a one-cycle valid strobe.
module amf_operand_fetch
    import amf_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 16,
    parameter int RW     = 3,
    parameter int DISP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic             is_dest,
    input  logic [DW-1:0]    value_field,
    input  logic [RW-1:0]    reg_sel,
    input  logic [AW-1:0]    pc,
    output logic [RW-1:0]    rf_addr,
    input  logic [DW-1:0]    rf_data,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_valid,
    output logic [DW-1:0]    operand,
    output logic [AW-1:0]    eff_addr,
    output logic [CNT_W-1:0] access_cnt,
    output logic             done,
    output logic             error
);
    amode_t           mode_q;
    logic             dest_q;
    logic [DW-1:0]    value_q;
    logic [RW-1:0]    reg_q;
    logic [AW-1:0]    pc_q;
    logic             accept;
    logic             busy;
    logic [AW-1:0]    first_addr;
    logic [DW-1:0]    direct_val;
    logic [CNT_W-1:0] nreads;

    // Capture the instruction fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= AM_IMM;
            dest_q  <= 1'b0;
            value_q <= '0;
            reg_q   <= '0;
            pc_q    <= '0;
        end else if (accept) begin
            mode_q  <= amode_t'(mode);
            dest_q  <= is_dest;
            value_q <= value_field;
            reg_q   <= reg_sel;
            pc_q    <= pc;
        end
    end

    assign rf_addr = reg_q;

    amf_ea_calc #(.DW(DW), .AW(AW), .DISP_W(DISP_W)) u_ea (
        .mode_i       (mode_q),
        .value_i      (value_q),
        .rf_val_i     (rf_data),
        .pc_i         (pc_q),
        .first_addr_o (first_addr),
        .direct_val_o (direct_val),
        .nreads_o     (nreads)
    );

    amf_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mode_q_i     (mode_q),
        .dest_q_i     (dest_q),
        .first_addr_i (first_addr),
        .direct_val_i (direct_val),
        .nreads_i     (nreads),
        .mem_valid_i  (mem_valid),
        .mem_rdata_i  (mem_rdata),
        .accept_o     (accept),
        .busy_o       (busy),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .operand_o    (operand),
        .eff_addr_o   (eff_addr),
        .access_cnt_o (access_cnt),
        .done_o       (done),
        .error_o      (error)
    );

    // R11: a start while busy leaves the captured instruction untouched
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(mode_q) && $stable(value_q) && $stable(reg_q)));

    // R1 / R2: modes without a memory operand never request
    p_noread_modes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == AM_IMM || mode_q == AM_REG)) |-> !mem_req);
endmodule

// File: tb/sim_amf_operand_fetch.sv
module sim_amf_operand_fetch;
    import amf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int RW = 3;
    localparam logic [15:0] SELF_A = 16'h0400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic          is_dest = 1'b0;
    logic [DW-1:0] value_field = '0;
    logic [RW-1:0] reg_sel = '0;
    logic [AW-1:0] pc = '0;
    logic [RW-1:0] rf_addr;
    logic [DW-1:0] rf_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_valid = 1'b0;
    logic [DW-1:0] operand;
    logic [AW-1:0] eff_addr;
    logic [1:0]    access_cnt;
    logic          done;
    logic          error;

    logic [DW-1:0] rf_arr [8];
    int checks = 0;
    int errors = 0;
    int resp_cnt = 0;
    int req_seen = 0;
    int wait_cnt = 0;

    assign rf_data = rf_arr[rf_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    amf_operand_fetch #(.DW(DW), .AW(AW), .RW(RW), .DISP_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_dest(is_dest),
        .value_field(value_field), .reg_sel(reg_sel), .pc(pc),
        .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .operand(operand), .eff_addr(eff_addr),
        .access_cnt(access_cnt), .done(done), .error(error)
    );

    function automatic logic [15:0] memf(logic [15:0] a);
        logic [31:0] h;
        if (a == SELF_A) return SELF_A;
        h = a * 32'd40503;
        return h[15:0] ^ 16'h3C5A;
    endfunction

    // Memory model: one-cycle valid after a random 0..2 cycle wait.
    initial begin
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req) begin
                req_seen++;
                if (wait_cnt == 0) begin
                    mem_valid = 1'b1;
                    mem_rdata = memf(mem_addr);
                    resp_cnt++;
                    wait_cnt  = $urandom_range(0, 2);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result from the requirements.
    task automatic model(input logic [2:0] m, input logic [15:0] v, input logic [15:0] rv,
                         input logic [15:0] p, output logic [15:0] op,
                         output logic [15:0] ea, output int n);
        logic [15:0] a;
        case (m)
            3'd0: begin op = v; ea = 0; n = 0; end
            3'd1: begin op = rv; ea = 0; n = 0; end
            3'd2: begin ea = v; n = 1; op = memf(ea); end
            3'd3: begin ea = memf(v); n = 2; op = memf(ea); end
            3'd4: begin ea = v + rv; n = 1; op = memf(ea); end
            3'd5: begin ea = rv; n = 1; op = memf(ea); end
            3'd6: begin ea = p + {{8{v[7]}}, v[7:0]}; n = 1; op = memf(ea); end
            default: begin a = memf(v); ea = memf(a); n = 3; op = memf(ea); end
        endcase
    endtask

    task automatic run_op(string req, logic [2:0] m, logic d, logic [15:0] v,
                          logic [2:0] r, logic [15:0] p, bit poke_busy);
        logic [15:0] eop, eea;
        int en, guard;
        model(m, v, rf_arr[r], p, eop, eea, en);
        @(negedge clk);
        resp_cnt = 0; req_seen = 0;
        mode = m; is_dest = d; value_field = v; reg_sel = r; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            mode = 3'd0; value_field = 16'hDEAD; is_dest = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        check({req, " done seen"}, done, 1);
        if (m == 3'd0 && d) begin
            check({req, " R9 error"}, error, 1);
            check({req, " R9 count"}, access_cnt, 0);
            check({req, " R9 no request"}, req_seen, 0);
        end else begin
            check({req, " error"}, error, 0);
            check({req, " operand"}, operand, eop);
            check({req, " eff_addr"}, eff_addr, eea);
            check({req, " count"}, access_cnt, en);
            check({req, " R10 valid strobes"}, resp_cnt, en);
        end
        @(negedge clk);
        check({req, " R10 done pulse"}, done, 0);
        if (poke_busy) begin
            repeat (4) begin
                @(negedge clk);
                check({req, " R11 no extra op"}, {30'd0, done, mem_req}, 0);
            end
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rf_arr[0] = 16'h0000;
        rf_arr[1] = 16'h1234;
        rf_arr[2] = 16'hFFE0;      // -32
        rf_arr[3] = 16'h0020;
        rf_arr[4] = 16'h0400;
        rf_arr[5] = 16'h8001;
        rf_arr[6] = 16'h7FFF;
        rf_arr[7] = 16'h00A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset done",  done, 0);
        check("R12 reset error", error, 0);
        check("R12 reset req",   mem_req, 0);
        check("R12 reset count", access_cnt, 0);

        run_op("R1 immediate",             3'd0, 0, 16'hBEEF, 3'd1, 16'h0100, 0);
        run_op("R2 register",              3'd1, 0, 16'h0000, 3'd5, 16'h0100, 0);
        run_op("R2 register as dest",      3'd1, 1, 16'h0000, 3'd1, 16'h0100, 0);
        run_op("R3 direct",                3'd2, 0, 16'h0123, 3'd0, 16'h0100, 0);
        run_op("R4 indirect",              3'd3, 0, 16'h0042, 3'd0, 16'h0100, 0);
        run_op("R4 self pointer",          3'd3, 0, SELF_A,   3'd0, 16'h0100, 0);
        run_op("R5 indexed negative wrap", 3'd4, 0, 16'h0010, 3'd2, 16'h0100, 0);
        run_op("R5 indexed overflow wrap", 3'd4, 0, 16'hFFF0, 3'd3, 16'h0100, 0);
        run_op("R5 indexed zero index",    3'd4, 0, 16'h0777, 3'd0, 16'h0100, 0);
        run_op("R6 register indirect",     3'd5, 0, 16'h0000, 3'd4, 16'h0100, 0);
        run_op("R7 pc relative zero",      3'd6, 0, 16'hAB00, 3'd0, 16'h2000, 0);
        run_op("R7 pc relative negative",  3'd6, 0, 16'h00F0, 3'd0, 16'h0005, 0);
        run_op("R8 double indirect",       3'd7, 0, 16'h0311, 3'd0, 16'h0100, 0);
        run_op("R8 double self pointer",   3'd7, 0, SELF_A,   3'd0, 16'h0100, 0);
        run_op("R9 immediate as dest",     3'd0, 1, 16'h5555, 3'd0, 16'h0100, 0);
        run_op("R11 start while busy",     3'd7, 0, 16'h0500, 3'd0, 16'h0100, 1);

        for (int i = 0; i < 200; i++) begin
            logic [2:0] rm;
            rm = 3'($urandom_range(0, 7));
            rf_arr[$urandom_range(0, 7)] = 16'($urandom);
            run_op("R10 random", rm, 1'($urandom_range(0, 1)), 16'($urandom),
                   3'($urandom_range(0, 7)), 16'($urandom), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule